// File: doc/BRIEF.md
# Search ROM accelerator sequencer

This block runs the bit-level part of a one-wire ROM search. While the search mode input is high, the host hands it one byte at a time. Each byte covers four consecutive ROM-ID positions and carries the host's preferred branch bit for each of them. For every position the sequencer asks an external slot engine for two read slots and then one write slot. It picks the bit to write from the two read results and the host's preference. When the fourth position is done, it returns a packed byte that holds the chosen path and a discrepancy flag for each position.

Sixteen bytes cover the 64 ID positions of one pass. An error is recorded when neither a device nor its complement answers a position. The error is sticky: it forces every later position to report path 1 and discrepancy 1, so path and discrepancy both 1 at the last position marks a failed pass. Sending the reset pulse, sending the search command byte and choosing the next pass's branch bits are left to other logic.

Top module: `srch_accel`

## Requirements
- R1: `in_ready` is high only while `acc_on` has been high for at least one full cycle and no byte is in progress. An accepted byte produces 12 slot requests, in the order read, read, write for each position (`slot_write` 0, 0, 1).
- R2: The branch bit for position j of a byte (j = 0..3, lowest position first) is input bit 2j+1. The even input bits have no effect on any output.
- R3: Write-slot bit: if the reads are (b0,b1) = (0,0), it is the branch bit. If they are (0,1) it is 0, and if they are (1,0) it is 1. If they are (1,1) it is 1.
- R4: The discrepancy flag is 1 for read pairs (0,0) and (1,1), and 0 for (0,1) and (1,0).
- R5: In the response byte, bit 2j+1 holds position j's written bit and bit 2j holds its discrepancy flag. `out_valid` is a single-cycle pulse in the cycle after the 12th slot completes.
- R6: After a (1,1) read pair, every later position in the pass writes 1 and reports path 1 and discrepancy 1. This lasts until `acc_on` changes.
- R7: Lowering or raising `acc_on` clears the error state and the byte count. Lowering it mid-byte abandons the byte with no response.
- R8: `pass_last` pulses together with `out_valid` for the 16th response byte after search mode was entered, and only for that byte.
- R9: While `acc_on` is low, `in_valid` is ignored: no slot is requested and no response appears.
- R10: `slot_start` is a one-cycle pulse. The next slot is not requested until `slot_done` has answered the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_on | input | 1 | Search mode enable |
| in_valid | input | 1 | Host byte present |
| in_byte | input | 8 | Host byte with branch bits on odd positions |
| in_ready | output | 1 | Sequencer can take a byte |
| slot_start | output | 1 | Request one bus slot |
| slot_write | output | 1 | Requested slot is a write (1) or read (0) |
| slot_wbit | output | 1 | Bit for a write slot |
| slot_done | input | 1 | Slot engine finished the current slot |
| slot_rbit | input | 1 | Sampled bus level for a read slot |
| out_valid | output | 1 | Response byte ready pulse |
| out_byte | output | 8 | Packed path and discrepancy bits |
| pass_last | output | 1 | Response is the last byte of the pass |

## Verification
The hardest state to reach from the ports is search mode being left in the middle of a byte while a slot is still outstanding. The bench's slot-engine model answers with a delay that changes from slot to slot. The bench drops `acc_on` once two slots of a byte have started, lets the late answer drain, and then confirms two things: no response appeared, and a fresh pass of sixteen bytes raises `pass_last` only on its last byte. The sticky error is brought about by scripting a read pair of (1,1) on a byte's first position. The bench then follows it over two bytes and one mode toggle.

// File: rtl/srch_accel.sv
module srch_accel #(
  parameter int ID_BITS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_on,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       in_ready,
  output logic       slot_start,
  output logic       slot_write,
  output logic       slot_wbit,
  input  logic       slot_done,
  input  logic       slot_rbit,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       pass_last
);
  localparam int NBYTE = ID_BITS / 4;
  localparam int BW = (NBYTE > 1) ? $clog2(NBYTE) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RD0, S_RD1, S_WR} st_t;

  st_t           st;
  logic          acc_q, issued, err_q, b0_q, b2_q, d_q;
  logic [1:0]    sub;
  logic [7:0]    byte_q, resp, resp_n;
  logic [BW-1:0] cnt;

  logic live, done, branch, none, conflict, b2_n, d_n;

  assign live       = acc_on && acc_q;
  assign in_ready   = live && (st == S_IDLE);
  assign slot_start = live && (st != S_IDLE) && !issued;
  assign slot_write = (st == S_WR);
  assign slot_wbit  = b2_q;
  assign done       = slot_done && issued;
  assign branch     = byte_q[{sub, 1'b1}];
  assign none       = b0_q && slot_rbit;
  assign conflict   = !b0_q && !slot_rbit;
  assign b2_n       = (err_q || none) ? 1'b1 : (conflict ? branch : b0_q);
  assign d_n        = err_q || none || conflict;

  always_comb begin
    resp_n = resp;
    resp_n[{sub, 1'b1}] = b2_q;
    resp_n[{sub, 1'b0}] = d_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      acc_q     <= 1'b0;
      issued    <= 1'b0;
      err_q     <= 1'b0;
      b0_q      <= 1'b0;
      b2_q      <= 1'b0;
      d_q       <= 1'b0;
      sub       <= '0;
      byte_q    <= '0;
      resp      <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_byte  <= '0;
      pass_last <= 1'b0;
    end else begin
      acc_q     <= acc_on;
      out_valid <= 1'b0;
      pass_last <= 1'b0;
      if (!live) begin
        st     <= S_IDLE;
        issued <= 1'b0;
        sub    <= '0;
        err_q  <= 1'b0;
        cnt    <= '0;
      end else begin
        if (slot_start) issued <= 1'b1;
        case (st)
          S_IDLE: if (in_valid) begin
            byte_q <= in_byte;
            sub    <= '0;
            st     <= S_RD0;
          end
          S_RD0: if (done) begin
            b0_q   <= slot_rbit;
            issued <= 1'b0;
            st     <= S_RD1;
          end
          S_RD1: if (done) begin
            b2_q   <= b2_n;
            d_q    <= d_n;
            err_q  <= err_q || none;
            issued <= 1'b0;
            st     <= S_WR;
          end
          S_WR: if (done) begin
            resp   <= resp_n;
            issued <= 1'b0;
            if (sub == 2'd3) begin
              out_byte  <= resp_n;
              out_valid <= 1'b1;
              pass_last <= (cnt == BW'(NBYTE - 1));
              cnt       <= cnt + 1'b1;
              st        <= S_IDLE;
            end else begin
              sub <= sub + 1'b1;
              st  <= S_RD0;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/srch_accel_chk.sv
module srch_accel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_on,
  input logic       acc_q,
  input logic [1:0] st,
  input logic       issued,
  input logic       err_q,
  input logic       b0_q,
  input logic       in_ready,
  input logic       slot_start,
  input logic       slot_write,
  input logic       slot_wbit,
  input logic       slot_done,
  input logic       slot_rbit,
  input logic       out_valid,
  input logic       pass_last
);
  // R1
  ready_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (acc_on && !slot_start));
  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R6
  err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_on && acc_q && st == 2'd2 && issued && slot_done && b0_q && slot_rbit) |=> err_q);
  // R6
  err_write_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && slot_start && slot_write) |-> slot_wbit);
  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(acc_on) || $fell(acc_on)) |=> !err_q);
  // R8
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_last |-> out_valid);
  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_on |-> (!slot_start && !in_ready));
  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> !slot_start);
endmodule

bind srch_accel srch_accel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_on(acc_on), .acc_q(acc_q), .st(st),
  .issued(issued), .err_q(err_q), .b0_q(b0_q), .in_ready(in_ready),
  .slot_start(slot_start), .slot_write(slot_write), .slot_wbit(slot_wbit),
  .slot_done(slot_done), .slot_rbit(slot_rbit), .out_valid(out_valid),
  .pass_last(pass_last)
);

// File: tb/srch_accel_bench.sv
module srch_accel_bench;
  logic clk = 1'b0, rst_n = 1'b0, acc_on = 1'b0, in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_ready, slot_start, slot_write, slot_wbit, out_valid, pass_last;
  logic slot_done = 1'b0, slot_rbit = 1'b0;
  logic [7:0] out_byte;

  always #4 clk = ~clk;

  srch_accel u_srch_accel (.*);

  int errors = 0, checks = 0, cyc = 0;
  logic [7:0] cur_rd = '0;
  logic [3:0] wr_bits = '0;
  int sc = 0, nstart = 0, cnt = 0, perr = 0;
  logic got_v, got_pl;
  logic [7:0] got_ob;

  // {branch byte, read pattern (b0=bit 2j, b1=bit 2j+1), expected response, expected writes}
  localparam logic [27:0] VEC [6] = '{
    {8'h00, 8'h86, 8'h18, 4'h2},
    {8'hAA, 8'h00, 8'hFF, 4'hF},
    {8'h88, 8'h00, 8'hDD, 4'hA},
    {8'hFF, 8'h55, 8'hAA, 4'hF},
    {8'h55, 8'h00, 8'h55, 4'h0},
    {8'h00, 8'hAA, 8'h00, 4'h0}
  };

  always @(negedge clk) begin
    cyc++;
    slot_done = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) slot_done = 1'b1;
    end else if (slot_start) begin
      int pos, ph;
      pos = (sc / 3) % 4;
      ph = sc % 3;
      if (slot_write != (ph == 2)) perr++;
      if (ph == 2) wr_bits[pos] = slot_wbit;
      else slot_rbit = cur_rd[2*pos + ph];
      nstart++;
      sc++;
      cnt = 1 + (sc % 3);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_byte(input logic [7:0] br, input logic [7:0] rd);
    int t;
    cur_rd = rd; sc = 0; nstart = 0; perr = 0; wr_bits = '0;
    t = 0;
    while (!in_ready && t < 100) begin @(negedge clk); t++; end
    in_valid = 1'b1; in_byte = br;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_out(input int lim);
    got_v = 1'b0; got_pl = 1'b0; got_ob = '0;
    for (int i = 0; i < lim && !got_v; i++) begin
      if (out_valid) begin got_v = 1'b1; got_ob = out_byte; got_pl = pass_last; end
      else @(negedge clk);
    end
  endtask

  task automatic run_byte(input logic [7:0] br, input logic [7:0] rd);
    start_byte(br, rd);
    wait_out(200);
  endtask

  task automatic toggle_mode;
    @(negedge clk); acc_on = 1'b0;
    repeat (3) @(negedge clk);
    acc_on = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !slot_start && !in_ready, "reset R1", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: input ignored while search mode is off
    nstart = 0;
    in_valid = 1'b1; in_byte = 8'hAA;
    got_v = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (out_valid) got_v = 1'b1;
    end
    in_valid = 1'b0;
    chk(nstart == 0 && !got_v && !in_ready, "R9 off", nstart, 0);

    acc_on = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      run_byte(VEC[v][27:20], VEC[v][19:12]);
      chk(got_v && got_ob == VEC[v][11:4], "R3 R4 R5 R2 response", got_ob, VEC[v][11:4]);
      chk(wr_bits == VEC[v][3:0], "R3 R2 written bits", wr_bits, VEC[v][3:0]);
      chk(nstart == 12 && perr == 0, "R1 R10 slot order", nstart, 12);
      chk(!got_pl, "R8 not last", got_pl, 0);
    end

    // R6: sticky error
    toggle_mode();
    run_byte(8'h00, 8'h4B);
    chk(got_v && got_ob == 8'hFF, "R6 error byte", got_ob, 8'hFF);
    chk(wr_bits == 4'hF, "R6 error writes", wr_bits, 4'hF);
    run_byte(8'h00, 8'hAA);
    chk(got_v && got_ob == 8'hFF, "R6 sticky next byte", got_ob, 8'hFF);
    toggle_mode();
    run_byte(8'h00, 8'hAA);
    chk(got_v && got_ob == 8'h00, "R7 error cleared", got_ob, 8'h00);

    // R7: leave mid-byte, then a fresh pass
    start_byte(8'h00, 8'hAA);
    while (nstart < 2 && cyc < 150000) @(negedge clk);
    acc_on = 1'b0;
    got_v = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (out_valid) got_v = 1'b1;
    end
    chk(!got_v, "R7 abandoned byte", got_v, 0);
    acc_on = 1'b1;
    repeat (2) @(negedge clk);
    for (int b = 0; b < 16; b++) begin
      run_byte(8'h00, 8'hAA);
      if (b < 15) chk(got_v && !got_pl, "R8 early byte", got_pl, 0);
      else chk(got_v && got_pl, "R8 last byte", got_pl, 1);
    end
    run_byte(8'h00, 8'hAA);
    chk(got_v && !got_pl, "R8 count wraps", got_pl, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule